// File: doc/BRIEF.md
# Bridge Short Fault Qualifier

This block turns the raw outputs of the short-to-supply and short-to-ground comparators on each half of a motor bridge into reliable fault flags. Each half has one gate switching command. When that command changes, the bridge output slews and the comparators may trip falsely. For a fixed blanking window after every change, all comparator activity on that half is ignored. Outside the window, a comparator must stay asserted for a full, selectable persistence time before a fault is accepted.

An accepted fault sets a sticky flag that stays set until a write-one-to-clear strobe removes it. A small configuration register sets the persistence time (four choices), the blanking length (two choices) and two 4-bit comparator sensitivity codes. The sensitivity codes are clamped to their legal minimums and driven out as registered values for the analog comparators. All times come from a clock assumed to run at 12 MHz, and each time is rounded up to whole cycles.

Top module: `sdq_short_qual`

## Requirements
- R1: After reset, every fault flag reads 0 and both level outputs read 6. The persistence code resets to 1 (12 cycles) and the blanking selection resets to short (9 cycles).
- R2: The persistence code `cfg_filt_sel` selects 2, 12, 24 or 36 consecutive qualifying samples for codes 0, 1, 2 and 3. A fault flag reads 1 after the clock edge that takes the last of those samples and reads 0 one cycle earlier.
- R3: A single sample with the comparator low restarts the persistence count from zero.
- R4: A change of `gate_cmd[i]` starts a blanking window for half i. The window covers the cycle of the change and lasts 9 cycles in total when the blanking selection is 0. Comparator samples of that half inside the window are ignored and clear its persistence counts.
- R5: With the blanking selection at 1, the window lasts 18 cycles.
- R6: A fault flag stays at 1 until a 1 on its clear bit, which removes it at the next edge. A new qualifying fault in the same cycle as the clear takes precedence, so the flag stays at 1.
- R7: `s2s_level_o` gives the written low-side code, raised to 1 if the code is 0. `s2g_level_o` gives the written high-side code, raised to 2 if the code is below 2. Both take effect at the edge that samples the write.
- R8: The configuration inputs have no effect while `cfg_wr` is 0.
- R9: The halves are independent: blanking or faults on one half do not affect another half.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock (12 MHz nominal) |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_filt_sel | input | 2 | Persistence time code |
| cfg_blank_long | input | 1 | Blanking selection: 0 short, 1 long |
| cfg_s2s_level | input | 4 | Low-side short-to-supply sensitivity code |
| cfg_s2g_level | input | 4 | High-side short-to-ground sensitivity code |
| gate_cmd | input | NUM_HALF | Gate switching command per half |
| cmp_s2s | input | NUM_HALF | Raw short-to-supply comparator per half |
| cmp_s2g | input | NUM_HALF | Raw short-to-ground comparator per half |
| clr_s2s | input | NUM_HALF | Write-one-to-clear for the short-to-supply flags |
| clr_s2g | input | NUM_HALF | Write-one-to-clear for the short-to-ground flags |
| s2s_level_o | output | 4 | Clamped, registered low-side sensitivity code |
| s2g_level_o | output | 4 | Clamped, registered high-side sensitivity code |
| fault_s2s | output | NUM_HALF | Latched short-to-supply fault flags |
| fault_s2g | output | NUM_HALF | Latched short-to-ground fault flags |

## Verification
A fault flag is due exactly L edges after the comparator first stays high, where L is the persistence length. After a gate change, it is due B+L edges after the change, where B is the blanking length. Level outputs and flag clears are due one edge after their strobe.

The bench drives every input on the falling edge and reads the outputs on later falling edges. It checks each flag both one edge before its due edge (expecting 0) and at its due edge (expecting 1), so an off-by-one in either counter is reported.

// File: rtl/sdq_pkg.sv
package sdq_pkg;

  // Round a time in ns up to whole clock cycles for a clock of mhz MHz.
  function automatic int unsigned ns_to_cyc(input int unsigned ns, input int unsigned mhz);
    return (ns * mhz + 999) / 1000;
  endfunction

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sdq_cfg.sv
module sdq_cfg #(
  parameter int unsigned CNT_W   = 6,
  parameter int unsigned LVL_W   = 4,
  parameter int unsigned F0_C    = 2,
  parameter int unsigned F1_C    = 12,
  parameter int unsigned F2_C    = 24,
  parameter int unsigned F3_C    = 36,
  parameter int unsigned BS_C    = 9,
  parameter int unsigned BL_C    = 18,
  parameter int unsigned S2S_MIN = 1,
  parameter int unsigned S2G_MIN = 2,
  parameter int unsigned S2S_RST = 6,
  parameter int unsigned S2G_RST = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_i,
  input  logic [1:0]       filt_sel_i,
  input  logic             blank_long_i,
  input  logic [LVL_W-1:0] s2s_lvl_i,
  input  logic [LVL_W-1:0] s2g_lvl_i,
  output logic [CNT_W-1:0] filt_len_o,
  output logic [CNT_W-1:0] blank_len_o,
  output logic [LVL_W-1:0] s2s_lvl_o,
  output logic [LVL_W-1:0] s2g_lvl_o
);

  localparam logic [LVL_W-1:0] S2S_LO = LVL_W'(S2S_MIN);
  localparam logic [LVL_W-1:0] S2G_LO = LVL_W'(S2G_MIN);

  logic [1:0]       sel_q, sel_d;
  logic             long_q, long_d;
  logic [LVL_W-1:0] s2s_q, s2s_d, s2g_q, s2g_d;
  logic [LVL_W-1:0] s2s_cl, s2g_cl;

  always_comb begin
    s2s_cl = (s2s_lvl_i < S2S_LO) ? S2S_LO : s2s_lvl_i;
    s2g_cl = (s2g_lvl_i < S2G_LO) ? S2G_LO : s2g_lvl_i;
    sel_d  = sel_q;
    long_d = long_q;
    s2s_d  = s2s_q;
    s2g_d  = s2g_q;
    if (wr_i) begin
      sel_d  = filt_sel_i;
      long_d = blank_long_i;
      s2s_d  = s2s_cl;
      s2g_d  = s2g_cl;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q  <= 2'd1;
      long_q <= 1'b0;
      s2s_q  <= LVL_W'(S2S_RST);
      s2g_q  <= LVL_W'(S2G_RST);
    end else begin
      sel_q  <= sel_d;
      long_q <= long_d;
      s2s_q  <= s2s_d;
      s2g_q  <= s2g_d;
    end
  end

  always_comb begin
    unique case (sel_q)
      2'd0:    filt_len_o = CNT_W'(F0_C);
      2'd1:    filt_len_o = CNT_W'(F1_C);
      2'd2:    filt_len_o = CNT_W'(F2_C);
      default: filt_len_o = CNT_W'(F3_C);
    endcase
    blank_len_o = long_q ? CNT_W'(BL_C) : CNT_W'(BS_C);
  end

  assign s2s_lvl_o = s2s_q;
  assign s2g_lvl_o = s2g_q;

endmodule

// File: rtl/sdq_blank.sv
module sdq_blank #(
  parameter int unsigned CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             gate_i,
  input  logic [CNT_W-1:0] blank_len_i,
  output logic             blank_o
);

  logic             gate_q;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             edge_w;

  assign edge_w = gate_i ^ gate_q;

  // The change cycle is the first blanked cycle; the counter covers the rest.
  always_comb begin
    cnt_d = cnt_q;
    if (edge_w) begin
      cnt_d = blank_len_i - CNT_W'(1);
    end else if (cnt_q != '0) begin
      cnt_d = cnt_q - CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gate_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      gate_q <= gate_i;
      cnt_q  <= cnt_d;
    end
  end

  assign blank_o = edge_w | (cnt_q != '0);

endmodule

// File: rtl/sdq_filt.sv
module sdq_filt #(
  parameter int unsigned CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmp_i,
  input  logic             blank_i,
  input  logic             clr_i,
  input  logic [CNT_W-1:0] filt_len_i,
  output logic             fault_o
);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] lim;
  logic             qual, hit;
  logic             fault_q, fault_d;

  assign lim  = filt_len_i - CNT_W'(1);
  assign qual = cmp_i & ~blank_i;
  assign hit  = qual && (cnt_q >= lim);

  always_comb begin
    if (!qual) begin
      cnt_d = '0;
    end else if (cnt_q < lim) begin
      cnt_d = cnt_q + CNT_W'(1);
    end else begin
      cnt_d = cnt_q;
    end
    // A new fault outranks a clear in the same cycle.
    fault_d = (fault_q & ~clr_i) | hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      fault_q <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      fault_q <= fault_d;
    end
  end

  assign fault_o = fault_q;

endmodule

// File: rtl/sdq_short_qual.sv
module sdq_short_qual
  import sdq_pkg::*;
#(
  parameter int unsigned NUM_HALF       = 3,
  parameter int unsigned CLK_MHZ        = 12,
  parameter int unsigned FILT0_NS       = 100,
  parameter int unsigned FILT1_NS       = 1000,
  parameter int unsigned FILT2_NS       = 2000,
  parameter int unsigned FILT3_NS       = 3000,
  parameter int unsigned BLANK_SHORT_NS = 750,
  parameter int unsigned BLANK_LONG_NS  = 1500,
  parameter int unsigned S2S_MIN        = 1,
  parameter int unsigned S2G_MIN        = 2,
  parameter int unsigned S2S_RST        = 6,
  parameter int unsigned S2G_RST        = 6
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_wr,
  input  logic [1:0]          cfg_filt_sel,
  input  logic                cfg_blank_long,
  input  logic [3:0]          cfg_s2s_level,
  input  logic [3:0]          cfg_s2g_level,
  input  logic [NUM_HALF-1:0] gate_cmd,
  input  logic [NUM_HALF-1:0] cmp_s2s,
  input  logic [NUM_HALF-1:0] cmp_s2g,
  input  logic [NUM_HALF-1:0] clr_s2s,
  input  logic [NUM_HALF-1:0] clr_s2g,
  output logic [3:0]          s2s_level_o,
  output logic [3:0]          s2g_level_o,
  output logic [NUM_HALF-1:0] fault_s2s,
  output logic [NUM_HALF-1:0] fault_s2g
);

  localparam int unsigned F0_C  = ns_to_cyc(FILT0_NS, CLK_MHZ);
  localparam int unsigned F1_C  = ns_to_cyc(FILT1_NS, CLK_MHZ);
  localparam int unsigned F2_C  = ns_to_cyc(FILT2_NS, CLK_MHZ);
  localparam int unsigned F3_C  = ns_to_cyc(FILT3_NS, CLK_MHZ);
  localparam int unsigned BS_C  = ns_to_cyc(BLANK_SHORT_NS, CLK_MHZ);
  localparam int unsigned BL_C  = ns_to_cyc(BLANK_LONG_NS, CLK_MHZ);
  localparam int unsigned MAX_C = max2(max2(max2(F0_C, F1_C), max2(F2_C, F3_C)), max2(BS_C, BL_C));
  localparam int unsigned CNT_W = $clog2(MAX_C + 1);

  logic [1:0]          rst_sync_q;
  logic                rst_int_n;
  logic [CNT_W-1:0]    filt_len;
  logic [CNT_W-1:0]    blank_len;
  logic [NUM_HALF-1:0] blank_act;

  // Reset asserts at once and releases two edges later.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_int_n = rst_sync_q[1];

  sdq_cfg #(
    .CNT_W(CNT_W), .LVL_W(4),
    .F0_C(F0_C), .F1_C(F1_C), .F2_C(F2_C), .F3_C(F3_C),
    .BS_C(BS_C), .BL_C(BL_C),
    .S2S_MIN(S2S_MIN), .S2G_MIN(S2G_MIN),
    .S2S_RST(S2S_RST), .S2G_RST(S2G_RST)
  ) u_cfg (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .wr_i        (cfg_wr),
    .filt_sel_i  (cfg_filt_sel),
    .blank_long_i(cfg_blank_long),
    .s2s_lvl_i   (cfg_s2s_level),
    .s2g_lvl_i   (cfg_s2g_level),
    .filt_len_o  (filt_len),
    .blank_len_o (blank_len),
    .s2s_lvl_o   (s2s_level_o),
    .s2g_lvl_o   (s2g_level_o)
  );

  for (genvar h = 0; h < NUM_HALF; h++) begin : g_half
    sdq_blank #(.CNT_W(CNT_W)) u_blank (
      .clk        (clk),
      .rst_n      (rst_int_n),
      .gate_i     (gate_cmd[h]),
      .blank_len_i(blank_len),
      .blank_o    (blank_act[h])
    );

    sdq_filt #(.CNT_W(CNT_W)) u_f_s2s (
      .clk       (clk),
      .rst_n     (rst_int_n),
      .cmp_i     (cmp_s2s[h]),
      .blank_i   (blank_act[h]),
      .clr_i     (clr_s2s[h]),
      .filt_len_i(filt_len),
      .fault_o   (fault_s2s[h])
    );

    sdq_filt #(.CNT_W(CNT_W)) u_f_s2g (
      .clk       (clk),
      .rst_n     (rst_int_n),
      .cmp_i     (cmp_s2g[h]),
      .blank_i   (blank_act[h]),
      .clr_i     (clr_s2g[h]),
      .filt_len_i(filt_len),
      .fault_o   (fault_s2g[h])
    );
  end

endmodule

// File: rtl/sdq_checker.sv
module sdq_checker #(
  parameter int unsigned NUM_HALF = 3
) (
  input logic                clk,
  input logic                rst_n,
  input logic [NUM_HALF-1:0] cmp_s2s,
  input logic [NUM_HALF-1:0] cmp_s2g,
  input logic [NUM_HALF-1:0] clr_s2s,
  input logic [NUM_HALF-1:0] clr_s2g,
  input logic [NUM_HALF-1:0] blank_act,
  input logic [NUM_HALF-1:0] fault_s2s,
  input logic [NUM_HALF-1:0] fault_s2g,
  input logic [3:0]          s2s_level_o,
  input logic [3:0]          s2g_level_o
);

  // R7
  s2s_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    s2s_level_o != 4'd0);

  // R7
  s2g_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    s2g_level_o >= 4'd2);

  for (genvar h = 0; h < NUM_HALF; h++) begin : g_chk
    // R6
    s2s_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fault_s2s[h] && !clr_s2s[h]) |=> fault_s2s[h]);

    // R6
    s2g_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fault_s2g[h] && !clr_s2g[h]) |=> fault_s2g[h]);

    // R2 R3 R4
    s2s_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(fault_s2s[h]) |-> ($past(cmp_s2s[h]) && $past(cmp_s2s[h], 2) && !$past(blank_act[h])));

    // R2 R3 R4
    s2g_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(fault_s2g[h]) |-> ($past(cmp_s2g[h]) && $past(cmp_s2g[h], 2) && !$past(blank_act[h])));
  end

endmodule

bind sdq_short_qual sdq_checker #(.NUM_HALF(NUM_HALF)) u_sdq_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .cmp_s2s    (cmp_s2s),
  .cmp_s2g    (cmp_s2g),
  .clr_s2s    (clr_s2s),
  .clr_s2g    (clr_s2g),
  .blank_act  (blank_act),
  .fault_s2s  (fault_s2s),
  .fault_s2g  (fault_s2g),
  .s2s_level_o(s2s_level_o),
  .s2g_level_o(s2g_level_o)
);

// File: tb/test_sdq_short_qual.sv
module test_sdq_short_qual;

  localparam int N = 3;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         cfg_wr;
  logic [1:0]   cfg_filt_sel;
  logic         cfg_blank_long;
  logic [3:0]   cfg_s2s_level, cfg_s2g_level;
  logic [N-1:0] gate_cmd, cmp_s2s, cmp_s2g, clr_s2s, clr_s2g;
  logic [3:0]   s2s_level_o, s2g_level_o;
  logic [N-1:0] fault_s2s, fault_s2g;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  sdq_short_qual #(.NUM_HALF(N)) i_sdq_short_qual (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_filt_sel(cfg_filt_sel),
    .cfg_blank_long(cfg_blank_long), .cfg_s2s_level(cfg_s2s_level),
    .cfg_s2g_level(cfg_s2g_level), .gate_cmd(gate_cmd), .cmp_s2s(cmp_s2s),
    .cmp_s2g(cmp_s2g), .clr_s2s(clr_s2s), .clr_s2g(clr_s2g),
    .s2s_level_o(s2s_level_o), .s2g_level_o(s2g_level_o),
    .fault_s2s(fault_s2s), .fault_s2g(fault_s2g)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_cfg(input logic [1:0] sel, input logic lng, input logic [3:0] a, input logic [3:0] b);
    cfg_filt_sel = sel; cfg_blank_long = lng; cfg_s2s_level = a; cfg_s2g_level = b;
    cfg_wr = 1'b1;
    step(1);
    cfg_wr = 1'b0;
  endtask

  task automatic clear_all();
    cmp_s2s = '0; cmp_s2g = '0;
    clr_s2s = '1; clr_s2g = '1;
    step(1);
    clr_s2s = '0; clr_s2g = '0;
    step(1);
  endtask

  // R1: reset values
  task automatic t_reset();
    chk("R1 fault_s2s", fault_s2s, 0);
    chk("R1 fault_s2g", fault_s2g, 0);
    chk("R1 s2s_level", s2s_level_o, 6);
    chk("R1 s2g_level", s2g_level_o, 6);
    // default persistence 12 cycles
    cmp_s2s[0] = 1'b1;
    step(11); chk("R1 default filter early", fault_s2s[0], 0);
    step(1);  chk("R1 default filter due", fault_s2s[0], 1);
    clear_all();
    chk("R1 cleared", fault_s2s[0], 0);
  endtask

  // R2: each persistence code, on s2s half 0 and s2g half 2
  task automatic t_filter();
    int len [4] = '{2, 12, 24, 36};
    for (int c = 0; c < 4; c++) begin
      wr_cfg(2'(c), 1'b0, 4'd6, 4'd6);
      cmp_s2s[0] = 1'b1; cmp_s2g[2] = 1'b1;
      step(len[c] - 1);
      chk($sformatf("R2 code%0d s2s early", c), fault_s2s[0], 0);
      chk($sformatf("R2 code%0d s2g early", c), fault_s2g[2], 0);
      step(1);
      chk($sformatf("R2 code%0d s2s due", c), fault_s2s[0], 1);
      chk($sformatf("R2 code%0d s2g due", c), fault_s2g[2], 1);
      clear_all();
    end
  endtask

  // R3: one low sample restarts the count
  task automatic t_restart();
    wr_cfg(2'd1, 1'b0, 4'd6, 4'd6);
    cmp_s2g[1] = 1'b1; step(6);
    cmp_s2g[1] = 1'b0; step(1);
    cmp_s2g[1] = 1'b1;
    step(11); chk("R3 restart early", fault_s2g[1], 0);
    step(1);  chk("R3 restart due", fault_s2g[1], 1);
    clear_all();
  endtask

  // R4 / R5: blanking windows
  task automatic t_blank(input logic lng, input int blen, input string tag);
    wr_cfg(2'd1, lng, 4'd6, 4'd6);
    gate_cmd[0] = ~gate_cmd[0];
    cmp_s2s[0] = 1'b1; cmp_s2g[0] = 1'b1;
    step(blen + 11);
    chk({tag, " s2s early"}, fault_s2s[0], 0);
    chk({tag, " s2g early"}, fault_s2g[0], 0);
    step(1);
    chk({tag, " s2s due"}, fault_s2s[0], 1);
    chk({tag, " s2g due"}, fault_s2g[0], 1);
    clear_all();
  endtask

  // R6: sticky flag, clear, set wins over clear
  task automatic t_sticky();
    wr_cfg(2'd0, 1'b0, 4'd6, 4'd6);
    cmp_s2s[2] = 1'b1; step(2);
    cmp_s2s[2] = 1'b0; step(5);
    chk("R6 held after comparator drop", fault_s2s[2], 1);
    cmp_s2s[2] = 1'b1; step(2);
    clr_s2s[2] = 1'b1; step(1); clr_s2s[2] = 1'b0;
    chk("R6 set wins over clear", fault_s2s[2], 1);
    cmp_s2s[2] = 1'b0; step(1);
    clr_s2s[2] = 1'b1; step(1); clr_s2s[2] = 1'b0;
    chk("R6 clear", fault_s2s[2], 0);
    step(1);
  endtask

  // R7: clamping of the level codes
  task automatic t_levels();
    wr_cfg(2'd1, 1'b0, 4'd0, 4'd0);
    chk("R7 s2s 0->1", s2s_level_o, 1);  chk("R7 s2g 0->2", s2g_level_o, 2);
    wr_cfg(2'd1, 1'b0, 4'd1, 4'd1);
    chk("R7 s2s 1", s2s_level_o, 1);     chk("R7 s2g 1->2", s2g_level_o, 2);
    wr_cfg(2'd1, 1'b0, 4'd2, 4'd2);
    chk("R7 s2s 2", s2s_level_o, 2);     chk("R7 s2g 2", s2g_level_o, 2);
    wr_cfg(2'd1, 1'b0, 4'd15, 4'd15);
    chk("R7 s2s 15", s2s_level_o, 15);   chk("R7 s2g 15", s2g_level_o, 15);
  endtask

  // R8: inputs ignored without cfg_wr
  task automatic t_ignore();
    wr_cfg(2'd1, 1'b0, 4'd9, 4'd9);
    cfg_filt_sel = 2'd0; cfg_blank_long = 1'b1;
    cfg_s2s_level = 4'd3; cfg_s2g_level = 4'd4;
    step(2);
    chk("R8 s2s level kept", s2s_level_o, 9);
    chk("R8 s2g level kept", s2g_level_o, 9);
    cmp_s2s[1] = 1'b1;
    step(2);  chk("R8 filter code kept (2)", fault_s2s[1], 0);
    step(9);  chk("R8 filter code kept (11)", fault_s2s[1], 0);
    step(1);  chk("R8 filter code kept (12)", fault_s2s[1], 1);
    clear_all();
  endtask

  // R9: halves independent
  task automatic t_indep();
    wr_cfg(2'd1, 1'b0, 4'd6, 4'd6);
    gate_cmd[1] = ~gate_cmd[1];
    cmp_s2s[0] = 1'b1; cmp_s2s[1] = 1'b1;
    step(12);
    chk("R9 half0 not blanked", fault_s2s[0], 1);
    chk("R9 half1 blanked", fault_s2s[1], 0);
    chk("R9 half2 untouched", fault_s2s[2], 0);
    step(9);
    chk("R9 half1 due", fault_s2s[1], 1);
    chk("R9 s2g untouched", fault_s2g, 0);
    clear_all();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cfg_wr = 1'b0; cfg_filt_sel = 2'd0; cfg_blank_long = 1'b0;
    cfg_s2s_level = 4'd0; cfg_s2g_level = 4'd0;
    gate_cmd = '0; cmp_s2s = '0; cmp_s2g = '0; clr_s2s = '0; clr_s2g = '0;
    step(4);
    rst_n = 1'b1;
    step(3);
    t_reset();
    t_filter();
    t_restart();
    t_blank(1'b0, 9,  "R4 short blank");
    t_blank(1'b1, 18, "R5 long blank");
    t_sticky();
    t_levels();
    t_ignore();
    t_indep();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule